// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block works next to the instruction sequencer of a small processor. At each instruction boundary it decides whether control passes to the kernel. Device controllers raise per-device request flags. A synchronous error or a trap instruction may also force entry, and an external signal line may request it. When entry happens, the block does four things in a single clock edge: it enters privileged mode, masks interrupts, turns off memory protection and steers the instruction counter to one shared handler address. It also records a cause code, the winning device number, the trap request number and the address of the next instruction.

The return instruction reverses the mode change in one indivisible step. It reloads the counter from the saved address, drops back to user mode and turns interrupts and protection back on. A request that is still waiting can therefore be taken at the very next boundary. Register saving, the handler table and the datapath belong to other blocks.

Top module: `intr_entry_seq`

## Requirements
- R1: During and after reset, `priv`=1, `ie`=0, `prot_en`=0, `pending`=0, and `pc_load` stays 0 while `exec_done` is low.
- R2: A 1 on `dev_req[i]` sets `pending[i]` at the next clock edge. The flag then stays set until a clear that is allowed to act.
- R3: `clr_en` clears the `pending` bits selected by `clr_mask`, but only while `priv`=1. In user mode it changes nothing. If a device sets a bit in the same cycle that the bit is cleared, the bit stays set.
- R4: `pc_load` can be 1 only in a cycle with `exec_done`=1. When `ie`=0 and there is no error or trap, a pending device or external request causes no entry.
- R5: On entry, `pc_load`=1 and `pc_target`=`HANDLER` in that same cycle. After that edge, `priv`=1, `ie`=0, `prot_en`=0, and `epc` holds the value `next_pc` had in the entry cycle.
- R6: On a device entry, the lowest-numbered pending device wins. Its index is written to `dev_code`.
- R7: Each cause has a 2-bit code: I/O completion=0, error=1, service request=2, external=3. The priority order is error, then trap, then external, then device. Error and trap entries do not depend on `ie`.
- R8: A trap entry sets cause 2 and copies `trap_num` into `svc_num`.
- R9: Return happens when `exec_done` and `rti` are both 1. In that cycle `pc_load`=1 and `pc_target`=`epc`. After the edge, `priv`=0, `ie`=1 and `prot_en`=1. No entry happens in a return cycle, even if one is requested. A request that is still pending is taken at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NDEV | Per-device request pulses |
| clr_en | input | 1 | Software clear strobe |
| clr_mask | input | NDEV | Flags to clear |
| err_req | input | 1 | Error at this boundary |
| ext_req | input | 1 | External signal request |
| trap_req | input | 1 | Trap instruction at this boundary |
| trap_num | input | NW | Service request number |
| exec_done | input | 1 | Execute step of current instruction finished |
| rti | input | 1 | Current instruction is a return |
| next_pc | input | AW | Counter of the next instruction |
| pc_load | output | 1 | Redirect the counter this cycle |
| pc_target | output | AW | Counter value to load |
| priv | output | 1 | Privileged mode |
| ie | output | 1 | Interrupt enable |
| prot_en | output | 1 | Memory protection enable |
| cause | output | 2 | Cause of the last entry |
| dev_code | output | DW | Device of the last device entry |
| svc_num | output | NW | Request number of the last trap |
| epc | output | AW | Saved return counter |
| pending | output | NDEV | Device request flags |

## Verification
The assertions assume a few things about the inputs. `rti`, `trap_req` and `err_req` are meaningful only together with `exec_done`. `clr_en` is treated as a software command, so the block's own privilege bit gates it. The stimulus raises the return, trap and error strobes only in boundary cycles, and otherwise holds them low. Reset separates the vector runs so that flags left over from one run cannot leak into the next.

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int NDEV = 8,
  parameter int AW = 16,
  parameter int NW = 8,
  parameter logic [AW-1:0] HANDLER = 16'h0100,
  localparam int DW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_req,
  input  logic            clr_en,
  input  logic [NDEV-1:0] clr_mask,
  input  logic            err_req,
  input  logic            ext_req,
  input  logic            trap_req,
  input  logic [NW-1:0]   trap_num,
  input  logic            exec_done,
  input  logic            rti,
  input  logic [AW-1:0]   next_pc,
  output logic            pc_load,
  output logic [AW-1:0]   pc_target,
  output logic            priv,
  output logic            ie,
  output logic            prot_en,
  output logic [1:0]      cause,
  output logic [DW-1:0]   dev_code,
  output logic [NW-1:0]   svc_num,
  output logic [AW-1:0]   epc,
  output logic [NDEV-1:0] pending
);
  localparam logic [1:0] C_IO = 2'd0, C_ERR = 2'd1, C_SVC = 2'd2, C_EXT = 2'd3;

  logic          ret, take;
  logic [DW-1:0] low_idx;
  logic [1:0]    next_cause;

  always_comb begin
    low_idx = '0;
    for (int i = NDEV - 1; i >= 0; i--)
      if (pending[i]) low_idx = DW'(i);
  end

  assign ret  = exec_done & rti;
  assign take = exec_done & ~rti &
                (err_req | trap_req | (ie & (ext_req | (|pending))));
  assign pc_load   = take | ret;
  assign pc_target = ret ? epc : HANDLER;

  assign next_cause = err_req  ? C_ERR :
                      trap_req ? C_SVC :
                      ext_req  ? C_EXT : C_IO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
    end else begin
      pending <= (pending & ~((clr_en & priv) ? clr_mask : '0)) | dev_req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv     <= 1'b1;
      ie       <= 1'b0;
      prot_en  <= 1'b0;
      cause    <= C_IO;
      dev_code <= '0;
      svc_num  <= '0;
      epc      <= '0;
    end else if (ret) begin
      priv    <= 1'b0;
      ie      <= 1'b1;
      prot_en <= 1'b1;
    end else if (take) begin
      priv    <= 1'b1;
      ie      <= 1'b0;
      prot_en <= 1'b0;
      cause   <= next_cause;
      epc     <= next_pc;
      if (next_cause == C_IO) dev_code <= low_idx;
      if (next_cause == C_SVC) svc_num <= trap_num;
    end
  end
endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
  parameter int NDEV = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDEV-1:0] dev_req,
  input logic            exec_done,
  input logic            rti,
  input logic            pc_load,
  input logic            priv,
  input logic            ie,
  input logic            prot_en,
  input logic [NDEV-1:0] pending
);
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_req) |=> ((pending & $past(dev_req)) == $past(dev_req)));

  assert_user_no_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |=> (($past(pending) & ~pending) == '0));

  assert_boundary_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_done |-> !pc_load);

  assert_entry_atomic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && !rti && pc_load) |=> (priv && !ie && !prot_en));

  assert_return_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && rti) |=> (!priv && ie && prot_en));
endmodule

bind intr_entry_seq intr_entry_seq_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .exec_done(exec_done),
  .rti(rti), .pc_load(pc_load), .priv(priv), .ie(ie), .prot_en(prot_en),
  .pending(pending)
);

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] dev_req = 0, clr_mask = 0, trap_num = 0;
  logic clr_en = 0, err_req = 0, ext_req = 0, trap_req = 0, exec_done = 0, rti = 0;
  logic [15:0] next_pc = 0;
  logic pc_load, priv, ie, prot_en;
  logic [15:0] pc_target, epc;
  logic [1:0] cause;
  logic [2:0] dev_code;
  logic [7:0] svc_num, pending;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .clr_en(clr_en), .clr_mask(clr_mask),
    .err_req(err_req), .ext_req(ext_req), .trap_req(trap_req), .trap_num(trap_num),
    .exec_done(exec_done), .rti(rti), .next_pc(next_pc), .pc_load(pc_load),
    .pc_target(pc_target), .priv(priv), .ie(ie), .prot_en(prot_en), .cause(cause),
    .dev_code(dev_code), .svc_num(svc_num), .epc(epc), .pending(pending));

  localparam logic [15:0] HND = 16'h0100;
  // {pattern, expected device, next_pc}
  localparam logic [26:0] VEC [5] = '{
    {8'b0000_0001, 3'd0, 16'h0200}, {8'b1000_0000, 3'd7, 16'h0302},
    {8'b0110_0000, 3'd5, 16'h0404}, {8'b1111_1110, 3'd1, 16'h0506},
    {8'b0001_0100, 3'd2, 16'h0608}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask
  task automatic settle; #1; endtask

  task automatic do_reset;
    rst_n = 0; tick; tick; rst_n = 1;
  endtask

  task automatic do_return;
    rti = 1; exec_done = 1; tick; rti = 0; exec_done = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset; settle;
    chk("R1 priv", priv, 1); chk("R1 ie", ie, 0); chk("R1 prot", prot_en, 0);
    chk("R1 pending", pending, 0); chk("R1 pc_load", pc_load, 0);

    for (int v = 0; v < 5; v++) begin
      do_reset; do_return;
      dev_req = VEC[v][26:19]; tick; dev_req = 0;
      next_pc = VEC[v][15:0]; exec_done = 1; settle;
      chk("R5 vec pc_load", pc_load, 1); chk("R5 vec target", pc_target, HND);
      tick; exec_done = 0;
      chk("R6 vec dev_code", dev_code, VEC[v][18:16]); chk("R7 vec cause io", cause, 0);
      chk("R5 vec epc", epc, VEC[v][15:0]);
      chk("R5 vec mode", {priv, ie, prot_en}, 3'b100);
    end

    // R4: no entry while masked; R2 hold
    do_reset; dev_req = 8'h08; tick; dev_req = 0;
    exec_done = 1; settle; chk("R4 masked no entry", pc_load, 0); tick; exec_done = 0;
    tick; tick; tick; chk("R2 flag held", pending, 8'h08);
    do_return;
    settle; chk("R4 no boundary no load", pc_load, 0);
    // R3 user-mode clear ignored
    clr_en = 1; clr_mask = 8'hFF; tick; clr_en = 0;
    chk("R3 user clear ignored", pending, 8'h08);
    next_pc = 16'h0ABC; exec_done = 1; tick; exec_done = 0;
    chk("R6 dev after hold", dev_code, 3);
    // R3 set wins over clear in privileged mode
    dev_req = 8'h01; clr_en = 1; clr_mask = 8'h01; tick; dev_req = 0; clr_en = 0;
    chk("R3 set beats clear", pending, 8'h09);
    clr_en = 1; clr_mask = 8'h09; tick; clr_en = 0;
    chk("R3 priv clear", pending, 8'h00);

    // R7 error taken while masked
    err_req = 1; trap_req = 1; next_pc = 16'h0C00; exec_done = 1; settle;
    chk("R7 err while masked", pc_load, 1); tick; err_req = 0; trap_req = 0; exec_done = 0;
    chk("R7 err cause", cause, 1);
    // R8 trap beats external
    trap_req = 1; ext_req = 1; trap_num = 8'h2A; next_pc = 16'h0D10; exec_done = 1; tick;
    trap_req = 0; exec_done = 0;
    chk("R8 svc cause", cause, 2); chk("R8 svc num", svc_num, 8'h2A);
    chk("R5 trap epc", epc, 16'h0D10);
    // R9 return wins over simultaneous trap, ext still requesting
    rti = 1; trap_req = 1; exec_done = 1; settle;
    chk("R9 ret load", pc_load, 1); chk("R9 ret target", pc_target, 16'h0D10);
    tick; rti = 0; trap_req = 0; exec_done = 0;
    chk("R9 ret mode", {priv, ie, prot_en}, 3'b011); chk("R9 cause kept", cause, 2);
    // R9 pending external taken at next boundary
    dev_req = 8'h04; tick; dev_req = 0;
    next_pc = 16'h0E00; exec_done = 1; settle; chk("R9 next entry", pc_load, 1);
    tick; exec_done = 0; ext_req = 0;
    chk("R7 ext over device", cause, 3); chk("R5 ext mode", {priv, ie, prot_en}, 3'b100);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule